// File: doc/BRIEF.md
# Round-Robin Serial ADC Channel Scanner

This block runs an SPI master that polls an external 8-channel, 10-bit serial converter without stopping. It visits the channels in a fixed cycle and keeps the most recent conversion for each channel in a bank of result registers. Any consumer can read that bank at any time through a channel-indexed read port.

Each conversion follows the same pattern. Chip select goes low and the block waits out a setup interval. It then shifts one 16-bit command/response frame, keeps the converter's 10-bit answer and raises chip select again. It waits a gap before starting on the next channel.

Each time a result register is written, a one-cycle strobe fires together with the index of the channel that was written. The SCK divider, the setup count and the gap count are all derived from the system clock frequency parameter.

Top module: `adc_scan`

## Requirements
- R1: Each conversion is one 16-bit frame, MSB first, in SPI mode 0. SCK is low whenever chip select is high. MOSI changes only on a falling SCK edge or when chip select falls. The converter's bit is sampled on the rising SCK edge. Exactly 16 rising edges occur per chip-select-low window.
- R2: The command word sent for channel c is 0x0100 | (c << 4). Bit 8 is the start bit and is 1. Bit 7 is 0, which selects single-ended mode. Bits 6:4 carry the channel number. All other bits are 0.
- R3: The stored result is the last 10 received bits, zero-extended to 16 bits. The first 6 received bits have no effect on the stored value.
- R4: Chip select is low for at least CS_SETUP_NS (108 ns) before the first rising SCK edge of a frame.
- R5: Chip select goes high in the same cycle that the result is stored. It stays high for at least GAP_NS (500 ns) before the next conversion begins.
- R6: Channels are converted in the order 0, 1, …, 7, and the scan wraps from 7 back to 0.
- R7: After reset every result register reads 0xFFFF. A channel that has not been converted yet keeps reading 0xFFFF.
- R8: The SCK period is at least 1/SCK_MAX_HZ (7.5 MHz, so at least 133.3 ns).
- R9: While reset is held, chip select is high and SCK is low. After reset is released, the first conversion is on channel 0.
- R10: `upd_valid_o` is high for exactly one cycle per stored result, and `upd_chan_o` names the channel in that cycle. The read port already shows the new value in that cycle.
- R11: `rd_data_o` shows the result register selected by `rd_chan_i` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |
| cs_no | output | 1 | Converter chip select, active low |
| rd_chan_i | input | 3 | Channel index for the read port |
| rd_data_o | output | 16 | Result register of the selected channel |
| upd_valid_o | output | 1 | One-cycle strobe when a result is stored |
| upd_chan_o | output | 3 | Channel stored in the strobe cycle |

## Verification
The hardest situation to bring about is one where the masking of the leading response bits actually matters. It only shows when those bits disagree with the zero-extension, and when the stored value sits at the 10-bit extremes.

The bench's converter model drives the six leading bits with random data on most frames. Directed frames pair an all-ones prefix with a zero result and an all-zero prefix with 0x3FF.

The scan also runs past two wraps so that the 7-to-0 transition is covered. Untouched channels are read back while the first pass is still in progress, to confirm they still hold 0xFFFF.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NUM_CH    = 8;
  localparam int CH_W      = 3;
  localparam int FRAME_W   = 16;
  localparam int RES_W     = 10;
  localparam int DATA_W    = 16;
  localparam int START_POS = 8;
  localparam int SGL_POS   = 7;
  localparam int CH_LSB    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_GAP} seq_state_e;

  function automatic logic [FRAME_W-1:0] cmd_word(input logic [CH_W-1:0] ch);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[START_POS] = 1'b1;
    w[SGL_POS]   = 1'b0;
    w[CH_LSB +: CH_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adc_scan_shift.sv
module adc_scan_shift import adc_scan_pkg::*; #(
  parameter int HALF_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] cmd_i,
  input  logic               start_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               done_o,
  output logic [RES_W-1:0]   rx_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_q;
  logic [RES_W-1:0]   rx_q;   // only the tail of the frame is retained
  logic               sck_q, act_q, done_q;
  logic [HW-1:0]      half_q;
  logic [BW-1:0]      bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      half_q <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) tx_q <= cmd_i;
      if (start_i) begin
        act_q  <= 1'b1;
        sck_q  <= 1'b0;
        half_q <= HW'(HALF_CYC - 1);
        bit_q  <= '0;
      end else if (act_q) begin
        if (half_q != '0) begin
          half_q <= half_q - 1'b1;
        end else begin
          half_q <= HW'(HALF_CYC - 1);
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[RES_W-2:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
            if (bit_q == BW'(FRAME_W - 1)) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[FRAME_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq import adc_scan_pkg::*; #(
  parameter int SETUP_CYC = 6,
  parameter int GAP_CYC   = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  output logic               cs_no,
  output logic               load_o,
  output logic [FRAME_W-1:0] cmd_o,
  output logic               start_o,
  output logic               wr_o,
  output logic [CH_W-1:0]    chan_o
);
  localparam int MAXC = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [CH_W-1:0]  chan_q, chan_nxt, ld_chan;

  assign chan_nxt = (chan_q == CH_W'(NUM_CH - 1)) ? '0 : chan_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_SETUP;
          cnt_q   <= CW'(SETUP_CYC - 1);
        end
        ST_SETUP: begin
          if (cnt_q == '0) state_q <= ST_XFER;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_XFER: begin
          if (done_i) begin
            state_q <= ST_GAP;
            cnt_q   <= CW'(GAP_CYC - 1);
          end
        end
        ST_GAP: begin
          if (cnt_q == '0) begin
            state_q <= ST_SETUP;
            cnt_q   <= CW'(SETUP_CYC - 1);
            chan_q  <= chan_nxt;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // command is loaded on the edge that drops chip select
  assign ld_chan = (state_q == ST_IDLE) ? chan_q : chan_nxt;
  assign load_o  = (state_q == ST_IDLE) || (state_q == ST_GAP && cnt_q == '0);
  assign cmd_o   = cmd_word(ld_chan);
  assign start_o = (state_q == ST_SETUP) && (cnt_q == '0);
  assign wr_o    = (state_q == ST_XFER) && done_i;
  assign cs_no   = !((state_q == ST_SETUP) || (state_q == ST_XFER));
  assign chan_o  = chan_q;
endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank import adc_scan_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [RES_W-1:0]  wr_data_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              upd_valid_o,
  output logic [CH_W-1:0]   upd_chan_o
);
  logic [DATA_W-1:0] regs_q [NUM_CH];
  logic              upd_q;
  logic [CH_W-1:0]   upd_ch_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[i] <= '1;
      else if (wr_i && (wr_chan_i == CH_W'(i)))      regs_q[i] <= {{(DATA_W-RES_W){1'b0}}, wr_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q    <= 1'b0;
      upd_ch_q <= '0;
    end else begin
      upd_q    <= wr_i;
      if (wr_i) upd_ch_q <= wr_chan_i;
    end
  end

  assign rd_data_o   = regs_q[rd_chan_i];
  assign upd_valid_o = upd_q;
  assign upd_chan_o  = upd_ch_q;
endmodule

// File: rtl/adc_scan.sv
module adc_scan import adc_scan_pkg::*; #(
  parameter int SYS_CLK_HZ  = 50_000_000,
  parameter int SCK_MAX_HZ  = 7_500_000,
  parameter int CS_SETUP_NS = 108,
  parameter int GAP_NS      = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              upd_valid_o,
  output logic [CH_W-1:0]   upd_chan_o
);
  localparam int HALF_RAW  = (SYS_CLK_HZ + 2*SCK_MAX_HZ - 1) / (2*SCK_MAX_HZ);
  localparam int HALF_CYC  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int SETUP_RAW = ((SYS_CLK_HZ / 1000) * CS_SETUP_NS + 999_999) / 1_000_000;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int GAP_RAW   = ((SYS_CLK_HZ / 1000) * GAP_NS + 999_999) / 1_000_000;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;

  logic               load, start, done, wr;
  logic [FRAME_W-1:0] cmd;
  logic [RES_W-1:0]   rx;
  logic [CH_W-1:0]    chan;

  adc_scan_seq #(.SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk_i, .rst_ni, .done_i(done), .cs_no, .load_o(load), .cmd_o(cmd),
    .start_o(start), .wr_o(wr), .chan_o(chan)
  );

  adc_scan_shift #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .cmd_i(cmd), .start_i(start),
    .miso_i, .sck_o, .mosi_o, .done_o(done), .rx_o(rx)
  );

  adc_scan_bank u_bank (
    .clk_i, .rst_ni, .wr_i(wr), .wr_chan_i(chan), .wr_data_i(rx),
    .rd_chan_i, .rd_data_o, .upd_valid_o, .upd_chan_o
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk import adc_scan_pkg::*; #(
  parameter int SYS_CLK_HZ  = 50_000_000,
  parameter int CS_SETUP_NS = 108,
  parameter int GAP_NS      = 500
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sck_o,
  input logic            mosi_o,
  input logic            cs_no,
  input logic            upd_valid_o,
  input logic [CH_W-1:0] upd_chan_o
);
  localparam int SETUP_MIN = ((SYS_CLK_HZ / 1000) * CS_SETUP_NS + 999_999) / 1_000_000;
  localparam int GAP_MIN   = ((SYS_CLK_HZ / 1000) * GAP_NS + 999_999) / 1_000_000;

  logic [15:0]     lo_cnt, hi_cnt;
  logic [5:0]      rise_cnt;
  logic            sck_d, seen_q;
  logic [CH_W-1:0] exp_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0; hi_cnt <= '0; rise_cnt <= '0;
      sck_d <= 1'b0; seen_q <= 1'b0; exp_ch <= '0;
    end else begin
      sck_d <= sck_o;
      if (cs_no) begin
        lo_cnt <= '0;
        rise_cnt <= '0;
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        if (sck_o && !sck_d) rise_cnt <= rise_cnt + 1'b1;
      end
      if (upd_valid_o) begin
        seen_q <= 1'b1;
        exp_ch <= (exp_ch == CH_W'(NUM_CH - 1)) ? '0 : exp_ch + 1'b1;
      end
    end
  end

  p_sck_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_mosi_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$stable(mosi_o)) |-> ($fell(sck_o) || $fell(cs_no)));
  p_rise_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_cnt == 6'd16));
  p_cs_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> (lo_cnt >= 16'(SETUP_MIN)));
  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_q) |-> (hi_cnt >= 16'(GAP_MIN)));
  p_cs_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> cs_no);
  p_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_chan_o == exp_ch));
  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |=> !upd_valid_o);
endmodule

bind adc_scan adc_scan_chk #(
  .SYS_CLK_HZ(SYS_CLK_HZ), .CS_SETUP_NS(CS_SETUP_NS), .GAP_NS(GAP_NS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no),
  .upd_valid_o(upd_valid_o), .upd_chan_o(upd_chan_o)
);

// File: tb/adc_scan_test.sv
`timescale 1ns/1ps
module adc_scan_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sck_o, mosi_o, miso_i, cs_no;
  logic [2:0]  rd_chan_i;
  logic [15:0] rd_data_o;
  logic        upd_valid_o;
  logic [2:0]  upd_chan_o;

  localparam real SETUP_NS = 108.0;
  localparam real GAP_NS_R = 500.0;
  localparam real MIN_PER  = 1.0e9 / 7.5e6;
  localparam int  N_CONV   = 20;

  int n_checks = 0, n_fail = 0;
  always #10 clk_i = ~clk_i;

  adc_scan uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // converter model and expected-value bookkeeping
  logic [15:0] exp_mem [8];
  logic [15:0] cmd_sh, resp;
  logic [9:0]  cur_val;
  logic [2:0]  exp_ch = 3'd0, last_ch = 3'd0;
  int          bitn = 0, conv_idx = 0;
  bit          started = 0, first_rise = 0, have_rise = 0;
  realtime     t_fall, t_rise, t_last;

  always @(negedge cs_no) if (rst_ni === 1'b1) begin
    if (have_rise)
      check(($realtime - t_rise) >= GAP_NS_R, "R5 gap", 32'($rtoi($realtime - t_rise)), 32'd500);
    started = 1; first_rise = 1; t_fall = $realtime; bitn = 0; cmd_sh = '0;
    if (conv_idx % 5 == 0)      begin cur_val = 10'h000; resp = {6'h3F, cur_val}; end
    else if (conv_idx % 5 == 1) begin cur_val = 10'h3FF; resp = {6'h00, cur_val}; end
    else begin cur_val = 10'($urandom); resp = {6'($urandom), cur_val}; end
    conv_idx++;
    miso_i = resp[15];
  end

  always @(posedge sck_o) begin
    if (first_rise)
      check(($realtime - t_fall) >= SETUP_NS, "R4 setup", 32'($rtoi($realtime - t_fall)), 32'd108);
    else
      check(($realtime - t_last) >= MIN_PER, "R8 sck period", 32'($rtoi($realtime - t_last)), 32'd134);
    first_rise = 0; t_last = $realtime;
    cmd_sh = {cmd_sh[14:0], mosi_o};
    bitn++;
  end

  always @(negedge sck_o) if (bitn < 16) miso_i = resp[15 - bitn];

  always @(posedge cs_no) if (started && rst_ni === 1'b1) begin
    check(bitn == 16, "R1 edges per frame", 32'(bitn), 32'd16);
    check(cmd_sh == (16'h0100 | (16'(exp_ch) << 4)), "R2 R6 command word", 32'(cmd_sh),
          32'(16'h0100 | (16'(exp_ch) << 4)));
    exp_mem[exp_ch] = {6'b0, cur_val};
    last_ch = exp_ch;
    exp_ch = exp_ch + 3'd1;
    t_rise = $realtime; have_rise = 1;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) exp_mem[i] = 16'hFFFF;
    rst_ni = 1'b0; rd_chan_i = '0; miso_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(cs_no === 1'b1, "R9 cs high in reset", 32'(cs_no), 32'd1);
    check(sck_o === 1'b0, "R9 sck low in reset", 32'(sck_o), 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd_chan_i = 3'(i); #1;
      check(rd_data_o === 16'hFFFF, "R7 R11 reset value", 32'(rd_data_o), 32'hFFFF);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 0; n < N_CONV; n++) begin
      do @(negedge clk_i); while (upd_valid_o !== 1'b1);
      check(upd_chan_o === last_ch, "R6 R9 R10 strobe channel", 32'(upd_chan_o), 32'(last_ch));
      check(cs_no === 1'b1, "R5 cs released at store", 32'(cs_no), 32'd1);
      rd_chan_i = upd_chan_o; #1;
      check(rd_data_o === exp_mem[last_ch], "R3 R10 stored value", 32'(rd_data_o), 32'(exp_mem[last_ch]));
      begin
        logic [2:0] rc;
        rc = 3'($urandom);
        rd_chan_i = rc; #1;
        check(rd_data_o === exp_mem[rc], (exp_mem[rc] == 16'hFFFF) ? "R7 untouched channel" : "R11 random read",
              32'(rd_data_o), 32'(exp_mem[rc]));
      end
      @(negedge clk_i);
      check(upd_valid_o === 1'b0, "R10 strobe width", 32'(upd_valid_o), 32'd0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule